// File: doc/BRIEF.md
# Register-Operand Network Port Unit

This unit sits between a processor's operand stage and a mesh network. Four register numbers, 24 to 27, are not storage. Each one is a window onto a network channel. When an instruction names one of them as a source, it takes the oldest word waiting in that channel's input queue. When an instruction names one of them as its destination, its result is sent into that channel's output queue. Every other register number reaches an ordinary 32-entry register file. Register 0 of that file always reads as zero.

Operands come out combinationally in the same cycle the decode stage presents its register numbers. This places network words on the same path as bypassed register values, so any instruction can consume or produce them without a load or a store. A source read only removes words from a queue in the cycle the instruction issues. Decode stalls while a queue it needs holds too few words. Writeback stalls while the output queue it targets is full.

On the network side, each channel has a 4-entry input queue and a 4-entry output queue. Both use valid/ready handshakes and keep words in arrival order.

Top module: `net_operand_if`

## Requirements
- R1: Register 0 reads as zero on both operands, and writes to register 0 are discarded.
- R2: A write to a register number in 1..23 or 28..31 is stored, and later reads return it. In the cycle of the write itself, a read of the same register returns the value being written.
- R3: A source operand naming register 24+k returns the oldest word in input queue k, with k in 0..3. The word is removed when the instruction issues, so successive issues see the words in arrival order.
- R4: When both operands name the same register 24+k, two successive words are consumed. Operand A gets the older word and operand B gets the next one.
- R5: dec_stall_o is 1 when dec_valid_i is 1 and some named input queue holds fewer words than the instruction needs (one per operand naming it). A stalled instruction removes nothing.
- R6: While dec_valid_i is 0, no word is removed from any input queue.
- R7: A writeback to register 24+k pushes wb_data_i into output queue k. Output queue k presents its words on net_out_valid_o[k] and bits [32k+31:32k] of net_out_data_o, oldest first. A word leaves the queue when net_out_ready_i[k] is 1. Other channels are not affected.
- R8: When output queue k already holds 4 words, a writeback to register 24+k raises wb_stall_o and the word is not stored.
- R9: net_in_ready_o[k] is 0 while input queue k holds 4 words. A word offered then is dropped.
- R10: Operands naming two different network registers each take one word from their own queue in the same issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_valid_i | input | 1 | Decode presents an instruction |
| dec_rs_a_i | input | 5 | Register number of source operand A |
| dec_rs_b_i | input | 5 | Register number of source operand B |
| dec_stall_o | output | 1 | Decode must hold its instruction |
| op_a_o | output | 32 | Value of operand A |
| op_b_o | output | 32 | Value of operand B |
| wb_valid_i | input | 1 | Writeback presents a result |
| wb_rd_i | input | 5 | Destination register number |
| wb_data_i | input | 32 | Result word |
| wb_stall_o | output | 1 | Writeback must hold its result |
| net_in_valid_i | input | 4 | Per-channel word offered by the network |
| net_in_data_i | input | 128 | Per-channel incoming words, channel k at [32k+31:32k] |
| net_in_ready_o | output | 4 | Per-channel input queue has room |
| net_out_valid_o | output | 4 | Per-channel output word available |
| net_out_data_o | output | 128 | Per-channel outgoing words, channel k at [32k+31:32k] |
| net_out_ready_i | input | 4 | Per-channel network accepts the word |

## Verification
The bench targets the double pop from one register, where a design that read the same head twice would return the same word on both operands. It targets a stall with exactly one word present when two are needed; a design that popped partially would lose that word, and the later issue would return the wrong pair. It also fills each queue to the brim. There, an overflowing design would accept a fifth word and either overwrite the oldest one or present it later. Register 0 and same-cycle writeback bypass are checked so that a design leaking stored or in-flight values through them returns nonzero or stale operands.

// File: rtl/net_operand_pkg.sv
package net_operand_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned REG_AW    = 5;
  localparam int unsigned NET_BASE  = 24;
  localparam int unsigned NET_PORTS = 4;
  localparam int unsigned Q_DEPTH   = 4;  // power of two, at least 2
endpackage

// File: rtl/net_in_queue.sv
module net_in_queue #(
  parameter int unsigned W     = net_operand_pkg::WORD_W,
  parameter int unsigned DEPTH = net_operand_pkg::Q_DEPTH,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  output logic          ready_o,
  input  logic [1:0]    pop_n_i,
  output logic [CW-1:0] count_o,
  output logic [W-1:0]  head0_o,
  output logic [W-1:0]  head1_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          acc;

  assign ready_o = (cnt_q < CW'(DEPTH));
  assign acc     = push_i & ready_o;
  assign count_o = cnt_q;
  assign head0_o = mem_q[rd_q];
  assign head1_o = mem_q[rd_q + PW'(1)];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else begin
      if (acc) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= wr_q + PW'(1);
      end
      rd_q  <= rd_q + PW'(pop_n_i);
      cnt_q <= cnt_q + CW'(acc) - CW'(pop_n_i);
    end
  end

  p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CW'(pop_n_i) <= cnt_q);
  p_fill_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/net_out_queue.sv
module net_out_queue #(
  parameter int unsigned W     = net_operand_pkg::WORD_W,
  parameter int unsigned DEPTH = net_operand_pkg::Q_DEPTH,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  input  logic         ready_i
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_q];
  assign pop     = valid_o & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= wr_q + PW'(1);
      end
      if (pop) rd_q <= rd_q + PW'(1);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop);
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);
  p_hold_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int unsigned W  = net_operand_pkg::WORD_W,
  parameter int unsigned AW = net_operand_pkg::REG_AW,
  localparam int unsigned N = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i,
  input  logic [AW-1:0] ra_a_i,
  input  logic [AW-1:0] ra_b_i,
  output logic [W-1:0]  rd_a_o,
  output logic [W-1:0]  rd_b_o
);
  logic [W-1:0] regs_q [N];

  assign rd_a_o = (ra_a_i == '0) ? '0 : regs_q[ra_a_i];
  assign rd_b_o = (ra_b_i == '0) ? '0 : regs_q[ra_b_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N); i++) regs_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      regs_q[wa_i] <= wd_i;
    end
  end
endmodule

// File: rtl/net_operand_if.sv
module net_operand_if
  import net_operand_pkg::*;
#(
  parameter int unsigned W     = WORD_W,
  parameter int unsigned AW    = REG_AW,
  parameter int unsigned BASE  = NET_BASE,
  parameter int unsigned PORTS = NET_PORTS,
  parameter int unsigned DEPTH = Q_DEPTH,
  localparam int unsigned PIW  = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dec_valid_i,
  input  logic [AW-1:0]      dec_rs_a_i,
  input  logic [AW-1:0]      dec_rs_b_i,
  output logic               dec_stall_o,
  output logic [W-1:0]       op_a_o,
  output logic [W-1:0]       op_b_o,
  input  logic               wb_valid_i,
  input  logic [AW-1:0]      wb_rd_i,
  input  logic [W-1:0]       wb_data_i,
  output logic               wb_stall_o,
  input  logic [PORTS-1:0]   net_in_valid_i,
  input  logic [PORTS*W-1:0] net_in_data_i,
  output logic [PORTS-1:0]   net_in_ready_o,
  output logic [PORTS-1:0]   net_out_valid_o,
  output logic [PORTS*W-1:0] net_out_data_o,
  input  logic [PORTS-1:0]   net_out_ready_i
);
  function automatic logic is_net(input logic [AW-1:0] r);
    return (r >= AW'(BASE)) && (r < AW'(BASE + PORTS));
  endfunction

  function automatic logic [PIW-1:0] port_of(input logic [AW-1:0] r);
    return PIW'(r - AW'(BASE));
  endfunction

  logic           net_a, net_b, net_w, same_ab;
  logic [PIW-1:0] idx_a, idx_b, idx_w;
  logic [W-1:0]   head0 [PORTS];
  logic [W-1:0]   head1 [PORTS];
  logic [CW-1:0]  cnt   [PORTS];
  logic [PORTS-1:0] short_k, full_k;
  logic           issue;
  logic [W-1:0]   gpr_a, gpr_b;
  logic           gpr_we;

  assign net_a   = is_net(dec_rs_a_i);
  assign net_b   = is_net(dec_rs_b_i);
  assign net_w   = is_net(wb_rd_i);
  assign idx_a   = port_of(dec_rs_a_i);
  assign idx_b   = port_of(dec_rs_b_i);
  assign idx_w   = port_of(wb_rd_i);
  assign same_ab = net_a && net_b && (idx_a == idx_b);

  assign dec_stall_o = dec_valid_i & (|short_k);
  assign issue       = dec_valid_i & ~(|short_k);
  assign wb_stall_o  = wb_valid_i & net_w & full_k[idx_w];
  assign gpr_we      = wb_valid_i & ~net_w;

  for (genvar k = 0; k < int'(PORTS); k++) begin : g_port
    logic [1:0] need;
    logic [1:0] pop_n;
    logic       push_out;

    assign need       = 2'(net_a && idx_a == PIW'(k)) + 2'(net_b && idx_b == PIW'(k));
    assign short_k[k] = CW'(need) > cnt[k];
    assign pop_n      = issue ? need : 2'd0;
    assign push_out   = wb_valid_i & net_w & (idx_w == PIW'(k)) & ~full_k[k];

    net_in_queue #(.W(W), .DEPTH(DEPTH)) i_in (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (net_in_valid_i[k]),
      .data_i  (net_in_data_i[k*W +: W]),
      .ready_o (net_in_ready_o[k]),
      .pop_n_i (pop_n),
      .count_o (cnt[k]),
      .head0_o (head0[k]),
      .head1_o (head1[k])
    );

    net_out_queue #(.W(W), .DEPTH(DEPTH)) i_out (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push_out),
      .data_i  (wb_data_i),
      .full_o  (full_k[k]),
      .valid_o (net_out_valid_o[k]),
      .data_o  (net_out_data_o[k*W +: W]),
      .ready_i (net_out_ready_i[k])
    );

    p_stall_keeps_words_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_stall_o && !net_in_valid_i[k]) |=> $stable(cnt[k]));
    p_idle_keeps_words_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!dec_valid_i && !net_in_valid_i[k]) |=> $stable(cnt[k]));
  end

  gpr_file #(.W(W), .AW(AW)) i_gpr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (gpr_we),
    .wa_i   (wb_rd_i),
    .wd_i   (wb_data_i),
    .ra_a_i (dec_rs_a_i),
    .ra_b_i (dec_rs_b_i),
    .rd_a_o (gpr_a),
    .rd_b_o (gpr_b)
  );

  // writeback bypass in front of the file, register 0 excluded
  always_comb begin
    if (net_a)
      op_a_o = head0[idx_a];
    else if (gpr_we && wb_rd_i == dec_rs_a_i && dec_rs_a_i != '0)
      op_a_o = wb_data_i;
    else
      op_a_o = gpr_a;

    if (net_b)
      op_b_o = same_ab ? head1[idx_b] : head0[idx_b];
    else if (gpr_we && wb_rd_i == dec_rs_b_i && dec_rs_b_i != '0)
      op_b_o = wb_data_i;
    else
      op_b_o = gpr_b;
  end

  p_zero_reg_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_rs_a_i == '0) |-> (op_a_o == '0));
  p_wb_net_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stall_o |-> (wb_valid_i && net_w));
endmodule

// File: tb/test_net_operand_if.sv
module test_net_operand_if;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dec_valid = 1'b0;
  logic [4:0]   rs_a = '0, rs_b = '0;
  logic         dec_stall;
  logic [31:0]  op_a, op_b;
  logic         wb_valid = 1'b0;
  logic [4:0]   wb_rd = '0;
  logic [31:0]  wb_data = '0;
  logic         wb_stall;
  logic [3:0]   in_valid = '0;
  logic [127:0] in_data = '0;
  logic [3:0]   in_ready;
  logic [3:0]   out_valid;
  logic [127:0] out_data;
  logic [3:0]   out_ready = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  net_operand_if i_net_operand_if (
    .clk_i(clk), .rst_ni(rst_n),
    .dec_valid_i(dec_valid), .dec_rs_a_i(rs_a), .dec_rs_b_i(rs_b),
    .dec_stall_o(dec_stall), .op_a_o(op_a), .op_b_o(op_b),
    .wb_valid_i(wb_valid), .wb_rd_i(wb_rd), .wb_data_i(wb_data), .wb_stall_o(wb_stall),
    .net_in_valid_i(in_valid), .net_in_data_i(in_data), .net_in_ready_o(in_ready),
    .net_out_valid_o(out_valid), .net_out_data_o(out_data), .net_out_ready_i(out_ready)
  );

  // {reg, written value, expected read}
  localparam logic [68:0] VEC [8] = '{
    {5'd1,  32'h1111_1111, 32'h1111_1111},
    {5'd0,  32'hDEAD_BEEF, 32'h0000_0000},
    {5'd23, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
    {5'd28, 32'h2828_0001, 32'h2828_0001},
    {5'd31, 32'hFFFF_0031, 32'hFFFF_0031},
    {5'd12, 32'h0000_00C0, 32'h0000_00C0},
    {5'd2,  32'h8000_0000, 32'h8000_0000},
    {5'd23, 32'h0BAD_F00D, 32'h0BAD_F00D}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push_in(input int k, input logic [31:0] d);
    in_valid[k] = 1'b1;
    in_data[k*32 +: 32] = d;
    step();
    in_valid[k] = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("reset stall R5", 32'(dec_stall), 32'd0);
    chk("reset in_ready R9", 32'(in_ready), 32'hF);
    chk("reset out_valid R7", 32'(out_valid), 32'h0);
    chk("reset op_a R1", op_a, 32'd0);

    // R1 and R2 through the vector table
    foreach (VEC[i]) begin
      @(negedge clk);
      wb_valid = 1'b1; wb_rd = VEC[i][68:64]; wb_data = VEC[i][63:32];
      rs_a = VEC[i][68:64]; rs_b = VEC[i][68:64];
      #1;
      chk("bypass R2/R1", op_a, VEC[i][31:0]);
      @(posedge clk);
      @(negedge clk);
      wb_valid = 1'b0;
      #1;
      chk("stored R2/R1", op_b, VEC[i][31:0]);
    end
    @(negedge clk);

    // R3, R4, R5, R6 on channel 0
    push_in(0, 32'hA000_0001);
    push_in(0, 32'hA000_0002);
    push_in(0, 32'hA000_0003);
    dec_valid = 1'b1; rs_a = 5'd24; rs_b = 5'd5;
    #1;
    chk("one word no stall R5", 32'(dec_stall), 32'd0);
    chk("oldest word R3", op_a, 32'hA000_0001);
    chk("plain reg beside port R2", op_b, 32'd0);
    step();
    rs_b = 5'd24;
    #1;
    chk("double pop A older R4", op_a, 32'hA000_0002);
    chk("double pop B next R4", op_b, 32'hA000_0003);
    step();
    rs_b = 5'd0;
    #1;
    chk("empty stall R5", 32'(dec_stall), 32'd1);
    step();
    dec_valid = 1'b0;
    push_in(0, 32'hA000_0004);
    dec_valid = 1'b1; rs_b = 5'd24;
    #1;
    chk("one of two stall R5", 32'(dec_stall), 32'd1);
    step();
    dec_valid = 1'b0;
    step();
    push_in(0, 32'hA000_0005);
    dec_valid = 1'b1;
    #1;
    chk("after stall no stall R5", 32'(dec_stall), 32'd0);
    chk("stall kept word R5/R6", op_a, 32'hA000_0004);
    chk("second word R4", op_b, 32'hA000_0005);
    step();
    dec_valid = 1'b0;

    // R10: two channels in one issue
    push_in(1, 32'hB000_0001);
    push_in(2, 32'hC000_0001);
    dec_valid = 1'b1; rs_a = 5'd25; rs_b = 5'd26;
    #1;
    chk("two ports stall R10", 32'(dec_stall), 32'd0);
    chk("port 25 word R10", op_a, 32'hB000_0001);
    chk("port 26 word R10", op_b, 32'hC000_0001);
    step();
    dec_valid = 1'b0;

    // R9: fill channel 3
    for (int i = 1; i <= 4; i++) push_in(3, 32'hD000_0000 + 32'(i));
    #1;
    chk("full input not ready R9", 32'(in_ready), 32'h7);
    push_in(3, 32'hD000_0005);
    dec_valid = 1'b1; rs_a = 5'd27; rs_b = 5'd27;
    #1;
    chk("fill order A R9", op_a, 32'hD000_0001);
    chk("fill order B R9", op_b, 32'hD000_0002);
    step();
    #1;
    chk("fill order C R9", op_a, 32'hD000_0003);
    chk("fill order D R9", op_b, 32'hD000_0004);
    step();
    rs_b = 5'd0;
    #1;
    chk("fifth word dropped R9", 32'(dec_stall), 32'd1);
    step();
    dec_valid = 1'b0;

    // R7, R8: output channel 0
    for (int i = 1; i <= 4; i++) begin
      wb_valid = 1'b1; wb_rd = 5'd24; wb_data = 32'hE000_0000 + 32'(i);
      #1;
      chk("out push no stall R7", 32'(wb_stall), 32'd0);
      step();
    end
    wb_data = 32'hE000_0005;
    #1;
    chk("full output stall R8", 32'(wb_stall), 32'd1);
    chk("only channel 0 valid R7", 32'(out_valid), 32'h1);
    chk("out head R7", out_data[31:0], 32'hE000_0001);
    step();
    wb_valid = 1'b0;
    out_ready[0] = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      #1;
      chk("out order R7", out_data[31:0], 32'hE000_0000 + 32'(i));
      step();
    end
    #1;
    chk("stalled word not stored R8", 32'(out_valid), 32'h0);
    out_ready = '0;
    rs_a = 5'd24;
    #1;
    chk("out write left inputs R7", 32'(in_ready), 32'hF);

    finish_run();
  end
endmodule